// File: doc/BRIEF.md
# Compressed-Table Sine Synthesizer

The block is a numerically controlled oscillator for a digital-to-analog converter. Each clock cycle with the enable high, a 32-bit tuning word is added to a phase register. The phase register wraps modulo 2^32. The top twelve phase bits are then turned into a 10-bit sine amplitude, which the block presents with a valid flag. The output frequency is the tuning word times the clock rate divided by 2^32.

The block keeps no full sine table. The two top phase bits fold the wave into one quarter: one bit reflects the address and the other negates the result. Within the quarter, the table stores only the residual left after a straight-line term proportional to phase is taken away. Four line segments, each with its own start value and slope, give a coarse estimate of that residual. A small signed correction table, one entry per address, supplies the remainder.

All tables are computed at elaboration from an integer series expansion. The datapath is a four-register pipeline.

Top module: `cdds_synth`

## Requirements
- R1: The 32-bit phase register adds `ftw_i` on every rising edge at which `en_i` is high, wrapping modulo 2^32. A synchronous active-low reset clears it to zero.
- R2: Only phase bits [31:20] affect the amplitude. Bits [19:0] of the phase never change the output sample.
- R3: For a phase index p = phase[31:20], `amp_o` is a two's complement value within 1 LSB of round(511·sin(2π(p+0.5)/4096)). This holds when OFFSET_BIN is 0. When OFFSET_BIN is 1, the MSB is inverted.
- R4: Indices p and p+2048 give exactly negated amplitudes (phase bit 31 negates).
- R5: For p below 2048, indices p and 2047−p give identical amplitudes (phase bit 30 reflects the 10-bit quarter address by bitwise inversion).
- R6: The sample whose phase is formed at rising edge E appears on `amp_o` after edge E+3. `valid_o` is high after edge E+3 exactly when `en_i` was high at edge E.
- R7: While `en_i` is low, the phase register holds its value and `valid_o` goes low four edges later.
- R8: With a tuning word of zero, successive valid samples are identical.
- R9: During reset, `amp_o` is 0 and `valid_o` is 0. The first valid sample after reset corresponds to phase equal to the tuning word.
- R10: `amp_o` never takes the value −512, and its magnitude never exceeds 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance the phase and issue a sample this cycle |
| ftw_i | input | 32 | Frequency tuning word added to the phase |
| amp_o | output | 10 | Sine amplitude, two's complement (or offset binary) |
| valid_o | output | 1 | High when `amp_o` carries a sample issued with enable |

## Verification
The bench sweeps every one of the 4096 phase indices and then compares mirrored and half-wave pairs exactly. A wrong fold shows up as a reflected quarter that is off by one address, or as a lower half-wave that is not negated. A slope sweep in the vectors crosses all four segment boundaries, where a correction entry taken from the wrong segment or an interpolation shift that rounds the wrong way moves the amplitude by several LSBs. Single-cycle enable pulses and a reset in the middle of a run pin down the latency of exactly four edges and the zero starting phase. A zero tuning word, and tuning words that differ only below the truncation point, expose a phase register that drifts or a mapping stage that reads the discarded bits.

// File: rtl/cdds_pkg.sv
// Package cdds_pkg
// Elaboration-time helpers that build the compressed sine tables.
// Assumes the quarter-wave address is at most 16 bits and the peak
// amplitude fits 15 bits, so that 64-bit fixed point cannot overflow.
package cdds_pkg;

    localparam longint PI_Q30   = 64'sd3373259426;  // pi scaled by 2^30
    localparam int     LIN_FRAC = 5;                // fraction bits of the line gain

    // Magnitude of the sine at quarter index idx, with a half-step centre.
    function automatic int sine_mag(input int idx, input int addr_w, input int peak);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (longint'(2 * idx + 1) * PI_Q30) >>> (addr_w + 2);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int k = 1; k <= 8; k++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
            sum  = sum + term;
        end
        return int'((sum * longint'(peak) + (64'sd1 <<< 29)) >>> 30);
    endfunction

    // Gain of the straight-line term, in units of 2^-LIN_FRAC per address step.
    function automatic int lin_gain(input int addr_w, input int peak);
        return int'((longint'(peak) * PI_Q30) >>> (addr_w + 1 + 30 - LIN_FRAC));
    endfunction

    // Residual left after the straight-line term is removed.
    function automatic int residual(input int idx, input int addr_w, input int peak);
        return sine_mag(idx, addr_w, peak) - ((idx * lin_gain(addr_w, peak)) >>> LIN_FRAC);
    endfunction

    // Residual at the start of segment k.
    function automatic int seg_base(input int k, input int addr_w, input int seg_bits, input int peak);
        return residual(k << (addr_w - seg_bits), addr_w, peak);
    endfunction

    // Rise of the residual across segment k.
    function automatic int seg_slope(input int k, input int addr_w, input int seg_bits, input int peak);
        return residual((k + 1) << (addr_w - seg_bits), addr_w, peak)
             - residual(k << (addr_w - seg_bits), addr_w, peak);
    endfunction

    // Correction entry: residual minus the line-segment estimate.
    function automatic int err_val(input int idx, input int addr_w, input int seg_bits, input int peak);
        int sh;
        int k;
        int f;
        int coarse;
        sh     = addr_w - seg_bits;
        k      = idx >> sh;
        f      = idx & ((1 << sh) - 1);
        coarse = seg_base(k, addr_w, seg_bits, peak)
               + ((seg_slope(k, addr_w, seg_bits, peak) * f) >>> sh);
        return residual(idx, addr_w, peak) - coarse;
    endfunction

endpackage

// File: rtl/cdds_phase_acc.sv
// Module cdds_phase_acc
// Phase register: adds the tuning word when enabled, wraps naturally,
// and exposes only the top TRUNC_W bits. Reset is synchronous, active low.
module cdds_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int TRUNC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] ftw_i,
    output logic [TRUNC_W-1:0] phase_o,
    output logic               vld_o
);

    logic [PHASE_W-1:0] acc_q;

    // Advance the phase and register the enable as the sample flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            vld_o <= 1'b0;
        end else begin
            if (en_i) begin
                acc_q <= acc_q + ftw_i;
            end
            vld_o <= en_i;
        end
    end

    assign phase_o = TRUNC_W'(acc_q >> (PHASE_W - TRUNC_W));

    // R1: an enabled edge adds exactly the tuning word, modulo 2^PHASE_W
    a_r1_advance : assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (acc_q == $past(acc_q) + $past(ftw_i)));

    // R7: a disabled edge leaves the phase untouched
    a_r7_hold_phase : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_q));

endmodule

// File: rtl/cdds_quarter_fold.sv
// Module cdds_quarter_fold
// Folds the truncated phase into one quarter wave. The second phase bit
// reflects the address by inversion, and the top bit is carried as a
// negate flag. Assumes TRUNC_W >= 3.
module cdds_quarter_fold #(
    parameter int TRUNC_W = 12,
    localparam int ADDR_W = TRUNC_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TRUNC_W-1:0] phase_i,
    input  logic               vld_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               neg_o,
    output logic               vld_o
);

    logic [ADDR_W-1:0] raw_addr;
    logic              reflect;

    // Split the phase into reflect flag and in-quarter address.
    always_comb begin
        raw_addr = phase_i[ADDR_W-1:0];
        reflect  = phase_i[TRUNC_W-2];
    end

    // Register the folded address, the negate flag and the sample flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            neg_o  <= 1'b0;
            vld_o  <= 1'b0;
        end else begin
            addr_o <= reflect ? ~raw_addr : raw_addr;
            neg_o  <= phase_i[TRUNC_W-1];
            vld_o  <= vld_i;
        end
    end

    // R6: the sample flag moves one stage per clock
    a_r6_valid_fold : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/cdds_resid_rom.sv
// Module cdds_resid_rom
// Table stage. It produces the straight-line term for the address, picks
// the start value and slope of one of 2^SEG_BITS segments, and reads the
// per-address correction entry. All tables are computed at elaboration.
// Assumes ERR_W is wide enough for the segment fit error.
module cdds_resid_rom #(
    parameter int ADDR_W   = 10,
    parameter int SEG_BITS = 2,
    parameter int PEAK     = 511,
    parameter int RES_W    = 11,
    parameter int ERR_W    = 6,
    parameter int LIN_W    = 11,
    localparam int FRAC_W  = ADDR_W - SEG_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    neg_i,
    input  logic                    vld_i,
    output logic [LIN_W-1:0]        lin_o,
    output logic signed [RES_W-1:0] base_o,
    output logic signed [RES_W-1:0] slope_o,
    output logic [FRAC_W-1:0]       frac_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    neg_o,
    output logic                    vld_o
);

    localparam int DEPTH = 2 ** ADDR_W;
    localparam int NSEG  = 2 ** SEG_BITS;
    localparam int GAIN  = cdds_pkg::lin_gain(ADDR_W, PEAK);

    logic signed [RES_W-1:0] base_tab  [NSEG];
    logic signed [RES_W-1:0] slope_tab [NSEG];
    logic signed [ERR_W-1:0] err_tab   [DEPTH];
    logic [SEG_BITS-1:0]     seg_sel;
    logic [31:0]             lin_full;

    // One start value and slope per segment.
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int BV = cdds_pkg::seg_base(s, ADDR_W, SEG_BITS, PEAK);
        localparam int SV = cdds_pkg::seg_slope(s, ADDR_W, SEG_BITS, PEAK);
        assign base_tab[s]  = RES_W'(BV);
        assign slope_tab[s] = RES_W'(SV);
    end

    // One small signed correction per quarter-wave address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_err
        localparam int EV = cdds_pkg::err_val(g, ADDR_W, SEG_BITS, PEAK);
        assign err_tab[g] = ERR_W'(EV);
    end

    // Segment index and straight-line term for the current address.
    always_comb begin
        seg_sel  = addr_i[ADDR_W-1 -: SEG_BITS];
        lin_full = 32'(addr_i) * 32'(GAIN);
    end

    // Register all table outputs for the reconstruction stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_o   <= '0;
            base_o  <= '0;
            slope_o <= '0;
            frac_o  <= '0;
            err_o   <= '0;
            neg_o   <= 1'b0;
            vld_o   <= 1'b0;
        end else begin
            lin_o   <= LIN_W'(lin_full >> cdds_pkg::LIN_FRAC);
            base_o  <= base_tab[seg_sel];
            slope_o <= slope_tab[seg_sel];
            frac_o  <= addr_i[FRAC_W-1:0];
            err_o   <= err_tab[addr_i];
            neg_o   <= neg_i;
            vld_o   <= vld_i;
        end
    end

    // R6: the sample flag moves one stage per clock
    a_r6_valid_rom : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/cdds_recon.sv
// Module cdds_recon
// Rebuilds the magnitude as line term + segment start + interpolated
// slope + correction, applies the half-wave sign, selects the output
// code and registers the sample. Assumes the rebuilt magnitude fits
// AMP_W-1 bits.
module cdds_recon #(
    parameter int AMP_W      = 10,
    parameter int PEAK       = 511,
    parameter int RES_W      = 11,
    parameter int ERR_W      = 6,
    parameter int LIN_W      = 11,
    parameter int FRAC_W     = 8,
    parameter int OFFSET_BIN = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LIN_W-1:0]        lin_i,
    input  logic signed [RES_W-1:0] base_i,
    input  logic signed [RES_W-1:0] slope_i,
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic                    neg_i,
    input  logic                    vld_i,
    output logic [AMP_W-1:0]        amp_o,
    output logic                    vld_o
);

    localparam int PW    = RES_W + FRAC_W + 1;
    localparam int SUM_W = RES_W + 2;

    logic signed [PW-1:0]    slope_x;
    logic signed [PW-1:0]    frac_x;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    interp;
    logic signed [SUM_W-1:0] mag_s;
    logic [AMP_W-1:0]        mag_t;
    logic [AMP_W-1:0]        amp_s;
    logic [AMP_W-1:0]        amp_fmt;

    // Interpolate within the segment and sum the four contributions.
    always_comb begin
        slope_x = PW'(slope_i);
        frac_x  = $signed(PW'({1'b0, frac_i}));
        prod    = slope_x * frac_x;
        interp  = prod >>> FRAC_W;
        mag_s   = $signed(SUM_W'(lin_i)) + SUM_W'(base_i)
                + SUM_W'(interp) + SUM_W'(err_i);
        mag_t   = AMP_W'(mag_s);
        amp_s   = neg_i ? (AMP_W'(0) - mag_t) : mag_t;
    end

    // Output code selected by parameter.
    if (OFFSET_BIN != 0) begin : g_offset
        assign amp_fmt = {~amp_s[AMP_W-1], amp_s[AMP_W-2:0]};
    end else begin : g_twos
        assign amp_fmt = amp_s;
    end

    // Register the final sample and its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_o <= '0;
            vld_o <= 1'b0;
        end else begin
            amp_o <= amp_fmt;
            vld_o <= vld_i;
        end
    end

    // R10: the rebuilt magnitude stays inside the positive amplitude range
    a_r10_mag_range : assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> ((mag_s >= 0) && (mag_s <= $signed(SUM_W'(PEAK)))));

    // R6: the sample flag moves one stage per clock
    a_r6_valid_out : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/cdds_synth.sv
// Module cdds_synth
// Top of the compressed-table sine synthesizer: phase register, quarter
// fold, table stage and reconstruction. Four registers deep, one sample
// per clock. Assumes TRUNC_W-2 > SEG_BITS.
module cdds_synth #(
    parameter int PHASE_W    = 32,
    parameter int TRUNC_W    = 12,
    parameter int AMP_W      = 10,
    parameter int SEG_BITS   = 2,
    parameter int ERR_W      = 6,
    parameter int OFFSET_BIN = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] ftw_i,
    output logic [AMP_W-1:0]   amp_o,
    output logic               valid_o
);

    localparam int ADDR_W = TRUNC_W - 2;
    localparam int FRAC_W = ADDR_W - SEG_BITS;
    localparam int PEAK   = 2 ** (AMP_W - 1) - 1;
    localparam int RES_W  = AMP_W + 1;
    localparam int LIN_W  = AMP_W + 1;

    logic [TRUNC_W-1:0]      ph;
    logic                    v1;
    logic [ADDR_W-1:0]       addr;
    logic                    neg2;
    logic                    v2;
    logic [LIN_W-1:0]        lin;
    logic signed [RES_W-1:0] base;
    logic signed [RES_W-1:0] slope;
    logic [FRAC_W-1:0]       frac;
    logic signed [ERR_W-1:0] err;
    logic                    neg3;
    logic                    v3;

    cdds_phase_acc #(
        .PHASE_W (PHASE_W),
        .TRUNC_W (TRUNC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .ftw_i   (ftw_i),
        .phase_o (ph),
        .vld_o   (v1)
    );

    cdds_quarter_fold #(
        .TRUNC_W (TRUNC_W)
    ) u_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (ph),
        .vld_i   (v1),
        .addr_o  (addr),
        .neg_o   (neg2),
        .vld_o   (v2)
    );

    cdds_resid_rom #(
        .ADDR_W   (ADDR_W),
        .SEG_BITS (SEG_BITS),
        .PEAK     (PEAK),
        .RES_W    (RES_W),
        .ERR_W    (ERR_W),
        .LIN_W    (LIN_W)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .neg_i   (neg2),
        .vld_i   (v2),
        .lin_o   (lin),
        .base_o  (base),
        .slope_o (slope),
        .frac_o  (frac),
        .err_o   (err),
        .neg_o   (neg3),
        .vld_o   (v3)
    );

    cdds_recon #(
        .AMP_W      (AMP_W),
        .PEAK       (PEAK),
        .RES_W      (RES_W),
        .ERR_W      (ERR_W),
        .LIN_W      (LIN_W),
        .FRAC_W     (FRAC_W),
        .OFFSET_BIN (OFFSET_BIN)
    ) u_recon (
        .clk     (clk),
        .rst_n   (rst_n),
        .lin_i   (lin),
        .base_i  (base),
        .slope_i (slope),
        .frac_i  (frac),
        .err_i   (err),
        .neg_i   (neg3),
        .vld_i   (v3),
        .amp_o   (amp_o),
        .vld_o   (valid_o)
    );

endmodule

// File: tb/cdds_synth_tb_top.sv
`timescale 1ns/1ps
// Bench for cdds_synth: a vector table of tuning words walked by one loop
// against an independent phase model, then directed reset and corner tests.
module cdds_synth_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [31:0] ftw_i = '0;
    logic [9:0]  amp_o;
    logic        valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model pipeline: phase after each edge and its enable
    logic [31:0] m_acc = '0;
    logic [31:0] md0 = '0, md1 = '0, md2 = '0, md3 = '0;
    logic        mv0 = 1'b0, mv1 = 1'b0, mv2 = 1'b0, mv3 = 1'b0;

    bit capture = 1'b0;
    int cap   [4096];
    bit cap_v [4096];
    int last_amp = 0;

    localparam logic [31:0] VEC_FTW [6] = '{32'h0010_0000, 32'h0123_4567, 32'h7FFF_FFFF,
                                            32'h8000_0000, 32'hFFF0_0000, 32'h0000_0001};
    localparam int          VEC_LEN [6] = '{4200, 400, 300, 100, 400, 100};

    always #2 clk = ~clk;  // 250 MHz

    cdds_synth dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .ftw_i   (ftw_i),
        .amp_o   (amp_o),
        .valid_o (valid_o)
    );

    // Independent model of phase and four-edge latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= '0;
            md0 <= '0; md1 <= '0; md2 <= '0; md3 <= '0;
            mv0 <= 1'b0; mv1 <= 1'b0; mv2 <= 1'b0; mv3 <= 1'b0;
        end else begin
            if (en_i) m_acc <= m_acc + ftw_i;
            md0 <= en_i ? m_acc + ftw_i : m_acc;
            mv0 <= en_i;
            md1 <= md0; md2 <= md1; md3 <= md2;
            mv1 <= mv0; mv2 <= mv1; mv3 <= mv2;
        end
    end

    function automatic int exp_amp(input logic [11:0] p);
        real th;
        real v;
        th = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0;
        v  = 511.0 * $sin(th);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One cycle: wait for the falling edge, then compare with the model.
    task automatic tick();
        int a;
        int e;
        @(negedge clk);
        a = int'($signed(amp_o));
        chk(valid_o == mv3, "R6 valid", int'(valid_o), int'(mv3));
        if (mv3 && valid_o) begin
            e = exp_amp(md3[31:20]);
            chk((a - e <= 1) && (e - a <= 1), "R3 amplitude", a, e);
            chk((a != -512) && (a <= 511) && (a >= -511), "R10 range", a, 511);
            if (capture) begin
                cap[md3[31:20]]   = a;
                cap_v[md3[31:20]] = 1'b1;
            end
            last_amp = a;
        end
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        repeat (n) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        int a1;
        int a0;
        // reset state (R9)
        do_reset(3);
        chk(valid_o == 1'b0, "R9 reset valid", int'(valid_o), 0);
        chk(amp_o == 10'd0, "R9 reset amp", int'(amp_o), 0);

        // vector walk (R1, R3, R10; first vector sweeps all indices)
        for (int i = 0; i < 6; i++) begin
            ftw_i   = VEC_FTW[i];
            en_i    = 1'b1;
            capture = (i == 0);
            repeat (VEC_LEN[i]) tick();
        end
        capture = 1'b0;

        // R4 and R5: exact symmetry across the sweep
        for (int p = 0; p < 4096; p++)
            chk(cap_v[p], "R3 sweep coverage", int'(cap_v[p]), 1);
        for (int p = 0; p < 1024; p++)
            chk(cap[p] == cap[2047 - p], "R5 quarter mirror", cap[2047 - p], cap[p]);
        for (int p = 0; p < 2048; p++)
            chk(cap[p + 2048] == -cap[p], "R4 half-wave negate", cap[p + 2048], -cap[p]);

        // R7: enable low drains valid and holds phase
        en_i = 1'b0;
        repeat (5) tick();
        chk(valid_o == 1'b0, "R7 valid after disable", int'(valid_o), 0);
        en_i = 1'b1;
        repeat (10) tick();

        // R8: zero tuning word keeps the output constant
        ftw_i = '0;
        repeat (5) tick();
        a0 = last_amp;
        for (int k = 0; k < 30; k++) begin
            tick();
            chk(int'($signed(amp_o)) == a0, "R8 constant output", int'($signed(amp_o)), a0);
        end

        // R6: a single enable pulse gives a single valid four edges on
        do_reset(2);
        en_i  = 1'b0;
        ftw_i = 32'h0200_0000;
        repeat (6) tick();
        en_i = 1'b1;
        tick();
        en_i = 1'b0;
        chk(valid_o == 1'b0, "R6 pulse edge0", int'(valid_o), 0);
        tick();
        chk(valid_o == 1'b0, "R6 pulse edge1", int'(valid_o), 0);
        tick();
        chk(valid_o == 1'b0, "R6 pulse edge2", int'(valid_o), 0);
        tick();
        chk(valid_o == 1'b1, "R6 pulse edge3", int'(valid_o), 1);
        chk((int'($signed(amp_o)) - exp_amp(12'h020) <= 1) && (exp_amp(12'h020) - int'($signed(amp_o)) <= 1),
            "R6 pulse sample", int'($signed(amp_o)), exp_amp(12'h020));
        tick();
        chk(valid_o == 1'b0, "R6 pulse edge4", int'(valid_o), 0);

        // R9: reset mid-run restarts phase from zero
        ftw_i = 32'h1234_5678;
        en_i  = 1'b1;
        repeat (20) tick();
        do_reset(2);
        repeat (4) tick();
        chk(valid_o == 1'b1, "R9 first valid", int'(valid_o), 1);
        chk((int'($signed(amp_o)) - exp_amp(12'h123) <= 1) && (exp_amp(12'h123) - int'($signed(amp_o)) <= 1),
            "R9 first sample phase", int'($signed(amp_o)), exp_amp(12'h123));

        // R2: bits below the truncation point do not change the sample
        ftw_i = 32'h0040_0000;
        do_reset(2);
        repeat (4) tick();
        a1 = int'($signed(amp_o));
        ftw_i = 32'h004F_FFFF;
        do_reset(2);
        repeat (4) tick();
        chk(int'($signed(amp_o)) == a1, "R2 truncation", int'($signed(amp_o)), a1);

        // R1: wrap after the largest step keeps tracking the model
        ftw_i = 32'hFFFF_FFFF;
        repeat (40) tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule